// File: doc/BRIEF.md
# Configurable Logic Cell Slice

This block is a row of `N` identical logic cells that share one set of clock-side controls. Every cell has a 16-entry truth table, one storage flop, a carry link to its upper neighbour and a cascade link that can AND its own table result with the neighbour below. Each cell runs in one of three operating styles chosen per cell at configuration time. In general style it is a 4-input table. In arithmetic style the table splits into a sum half and a carry half. In counter style it is one bit of a loadable up/down counter. Every cell presents both its combinational result and its flop value.

Configuration (styles, tables, carry-select, cascade-join and power-up polarity per cell) is taken in by a two-state sequencer. State `SL_CONFIG` is entered on chip reset. In it the configuration ports are copied on every clock edge and the cell flops hold. Transition `CONFIG_TO_RUN` fires on the first edge after reset is released. That edge still copies the configuration. State `SL_RUN` then persists until the next chip reset. Once in `SL_RUN` the configuration ports have no effect. An adder of width `W` uses `W` arithmetic cells plus one general-style cell that selects its carry-in as table input, so the final carry shows up on an ordinary output.

Top module: `lcell_slice`

## Requirements
- R1: While `rst_n` is low, each `reg_o` bit equals that cell's `cfg_pre_i` bit (1 means powers up high). Configuration is copied only in `SL_CONFIG`; changes to any `cfg_*` port during `SL_RUN` change nothing.
- R2: The first clock edge after `rst_n` rises is spent in `SL_CONFIG`. No flop changes on that edge, even with `ena_i` and `sload_i` high. Flops update from the second edge on.
- R3: A cell in general style (code 2'b00) outputs `lut[{d3, s, d1, d0}]`, where `s` is the carry-in if its `cfg_csel_i` bit is 1 and `d2` otherwise. Data nibble for cell i is `data_i[4i+3:4i]`, with d0 in the low bit.
- R4: In arithmetic style (code 2'b01), the result is `lut[{0, cin, d1, d0}]` and the carry-out is `lut[{1, cin, d1, d0}]`. Cell 0 takes its carry-in from `cin_i`. Cell i takes it from cell i-1. A general-style cell drives carry-out 0. `cout_o` is the carry-out of cell N-1.
- R5: In counter style (code 2'b10), d0 is the count enable and d1 selects up (1) or down (0). The combinational output is `q ^ (d0 & cin)`, and the carry-out is `cin & (d1 ? q : ~q)`. With `cin_i` = 1 the counter cells count as one binary number with cell 0 as LSB.
- R6: For a cell not in counter style whose `cfg_casc_i` bit is 1, the combinational output is its table result ANDed with the combinational output of cell i-1. Cell 0 joins with constant 1.
- R7: In `SL_RUN` with `ena_i` high and no clear or load, each flop takes its cell's combinational output.
- R8: With `ena_i` low, all flops hold, even when `sclr_i` or `sload_i` is high.
- R9: With `ena_i` high, `sclr_i` drives every flop to 0. It wins over `sload_i` and over the table or cascade result.
- R10: With `ena_i` high, `sload_i` high and `sclr_i` low, each flop takes d3 of its own cell.
- R11: `aclr_i` forces every flop to its power-up value at once, without a clock, and holds it there while high. It ranks below `rst_n` and does not affect the sequencer.
- R12: Style code 2'b11 behaves exactly like general style.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock |
| rst_n | input | 1 | Chip-wide reset, active low, asynchronous |
| aclr_i | input | 1 | Asynchronous flop clear to power-up value |
| ena_i | input | 1 | Clock enable for all cell flops |
| sclr_i | input | 1 | Synchronous clear of all flops |
| sload_i | input | 1 | Synchronous load of all flops from d3 |
| cin_i | input | 1 | Carry into cell 0 |
| data_i | input | 4*N | Four data inputs per cell, cell i at bits 4i+3:4i |
| cfg_mode_i | input | 2*N | Style code per cell, cell i at bits 2i+1:2i |
| cfg_lut_i | input | 16*N | Truth table per cell, cell i at bits 16i+15:16i |
| cfg_csel_i | input | N | Carry-in replaces d2 in general style |
| cfg_casc_i | input | N | Join with lower neighbour's output |
| cfg_pre_i | input | N | Power-up value of each flop |
| comb_o | output | N | Combinational output per cell |
| reg_o | output | N | Flop output per cell |
| cout_o | output | 1 | Carry-out of the top cell |

## Verification
The assertions take for granted that `aclr_i`, `sclr_i`, `sload_i`, `ena_i` and the data nibbles change only away from the rising clock edge. They also assume the configuration ports are only interesting while the sequencer is in `SL_CONFIG`. The stimulus moves every input one nanosecond after an edge. It drops `aclr_i` at the same point, so an asynchronous clear never overlaps a sampling edge. The bench deliberately changes the configuration ports during `SL_RUN` to show they are ignored. Random phases mix all four style codes, carry-select, cascade and power-up settings, with rare clears, loads and asynchronous clears.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

    localparam int LUT_IN   = 4;
    localparam int LUT_BITS = 1 << LUT_IN;
    localparam int MODE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        CM_NORMAL = 2'b00,
        CM_ARITH  = 2'b01,
        CM_COUNT  = 2'b10,
        CM_SPARE  = 2'b11
    } cell_mode_e;

    typedef enum logic {
        SL_CONFIG = 1'b0,
        SL_RUN    = 1'b1
    } slice_state_e;

endpackage

// File: rtl/lcell_cfg_ctrl.sv
module lcell_cfg_ctrl
    import lcell_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N*MODE_W-1:0]     cfg_mode_i,
    input  logic [N*LUT_BITS-1:0]   cfg_lut_i,
    input  logic [N-1:0]            cfg_csel_i,
    input  logic [N-1:0]            cfg_casc_i,
    input  logic [N-1:0]            cfg_pre_i,
    output logic [N*MODE_W-1:0]     mode_o,
    output logic [N*LUT_BITS-1:0]   lut_o,
    output logic [N-1:0]            csel_o,
    output logic [N-1:0]            casc_o,
    output logic [N-1:0]            pre_o,
    output logic                    run_o
);

    slice_state_e state_q, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SL_CONFIG;
        else        state_q <= state_nx;
    end

    // transitions: CONFIG_TO_RUN on the first edge out of reset
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            SL_CONFIG: state_nx = SL_RUN;
            SL_RUN:    state_nx = SL_RUN;
        endcase
    end

    // outputs
    always_comb begin
        run_o = 1'b0;
        unique case (state_q)
            SL_CONFIG: run_o = 1'b0;
            SL_RUN:    run_o = 1'b1;
        endcase
    end

    // configuration shadow, written only in SL_CONFIG
    always_ff @(posedge clk) begin
        if (state_q == SL_CONFIG) begin
            mode_o <= cfg_mode_i;
            lut_o  <= cfg_lut_i;
            csel_o <= cfg_csel_i;
            casc_o <= cfg_casc_i;
            pre_o  <= cfg_pre_i;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SL_RUN |=> ($stable(lut_o) && $stable(mode_o) && $stable(pre_o)
                               && $stable(csel_o) && $stable(casc_o))); // R1

    AST_ONE_CONFIG_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == SL_CONFIG |=> state_q == SL_RUN); // R2

endmodule

// File: rtl/lcell_fn.sv
module lcell_fn
    import lcell_pkg::*;
(
    input  cell_mode_e             mode_i,
    input  logic [LUT_BITS-1:0]    lut_i,
    input  logic                   csel_i,
    input  logic                   casc_i,
    input  logic [LUT_IN-1:0]      d_i,
    input  logic                   q_i,
    input  logic                   cin_i,
    input  logic                   cas_i,
    output logic                   f_o,
    output logic                   cout_o
);

    logic [LUT_IN-1:0] idx_n;
    logic [LUT_IN-2:0] idx_a;
    logic              g;

    always_comb begin
        idx_n  = {d_i[3], (csel_i ? cin_i : d_i[2]), d_i[1], d_i[0]};
        idx_a  = {cin_i, d_i[1], d_i[0]};
        g      = 1'b0;
        f_o    = 1'b0;
        cout_o = 1'b0;
        unique case (mode_i)
            CM_ARITH: begin
                g      = lut_i[{1'b0, idx_a}];
                cout_o = lut_i[{1'b1, idx_a}];
            end
            CM_COUNT: begin
                f_o    = q_i ^ (d_i[0] & cin_i);
                cout_o = cin_i & (d_i[1] ? q_i : ~q_i);
            end
            CM_NORMAL, CM_SPARE: begin
                g = lut_i[idx_n];
            end
        endcase
        if (mode_i != CM_COUNT) f_o = casc_i ? (g & cas_i) : g;
    end

endmodule

// File: rtl/lcell_reg.sv
module lcell_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic aclr_i,
    input  logic run_i,
    input  logic ena_i,
    input  logic sclr_i,
    input  logic sload_i,
    input  logic fn_i,
    input  logic ld_i,
    input  logic pre_i,
    output logic q_o
);

    logic raw_q;
    logic nxt;

    // clear beats load beats cell function
    always_comb begin
        nxt = fn_i;
        if (sclr_i)       nxt = 1'b0;
        else if (sload_i) nxt = ld_i;
    end

    // stored inverted for power-up-high cells, so every reset path is a clear
    always_ff @(posedge clk or negedge rst_n or posedge aclr_i) begin
        if (!rst_n)                raw_q <= 1'b0;
        else if (aclr_i)           raw_q <= 1'b0;
        else if (run_i && ena_i)   raw_q <= nxt ^ pre_i;
    end

    assign q_o = raw_q ^ pre_i;

    AST_SCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n || aclr_i)
        (run_i && ena_i && sclr_i) |=> (q_o == 1'b0)); // R9

    AST_SLOAD_D3: assert property (@(posedge clk) disable iff (!rst_n || aclr_i)
        (run_i && ena_i && !sclr_i && sload_i) |=> (q_o == $past(ld_i))); // R10

    AST_HOLD_NO_ENA: assert property (@(posedge clk) disable iff (!rst_n || aclr_i)
        (run_i && !ena_i) |=> $stable(q_o)); // R8

    AST_ACLR_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        aclr_i |-> (q_o == pre_i)); // R11

endmodule

// File: rtl/lcell_slice.sv
module lcell_slice
    import lcell_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  aclr_i,
    input  logic                  ena_i,
    input  logic                  sclr_i,
    input  logic                  sload_i,
    input  logic                  cin_i,
    input  logic [N*LUT_IN-1:0]   data_i,
    input  logic [N*MODE_W-1:0]   cfg_mode_i,
    input  logic [N*LUT_BITS-1:0] cfg_lut_i,
    input  logic [N-1:0]          cfg_csel_i,
    input  logic [N-1:0]          cfg_casc_i,
    input  logic [N-1:0]          cfg_pre_i,
    output logic [N-1:0]          comb_o,
    output logic [N-1:0]          reg_o,
    output logic                  cout_o
);

    logic [N*MODE_W-1:0]   mode_q;
    logic [N*LUT_BITS-1:0] lut_q;
    logic [N-1:0]          csel_q;
    logic [N-1:0]          casc_q;
    logic [N-1:0]          pre_q;
    logic                  run;

    lcell_cfg_ctrl #(.N(N)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_mode_i (cfg_mode_i),
        .cfg_lut_i  (cfg_lut_i),
        .cfg_csel_i (cfg_csel_i),
        .cfg_casc_i (cfg_casc_i),
        .cfg_pre_i  (cfg_pre_i),
        .mode_o     (mode_q),
        .lut_o      (lut_q),
        .csel_o     (csel_q),
        .casc_o     (casc_q),
        .pre_o      (pre_q),
        .run_o      (run)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic c_in;
        logic cas_in;
        logic f;
        logic c_out;
        logic q;
        logic [LUT_IN-1:0] d;

        assign d = data_i[i*LUT_IN +: LUT_IN];

        if (i == 0) begin : g_head
            assign c_in   = cin_i;
            assign cas_in = 1'b1;
        end else begin : g_link
            assign c_in   = g_cell[i-1].c_out;
            assign cas_in = g_cell[i-1].f;
        end

        lcell_fn u_fn (
            .mode_i (cell_mode_e'(mode_q[i*MODE_W +: MODE_W])),
            .lut_i  (lut_q[i*LUT_BITS +: LUT_BITS]),
            .csel_i (csel_q[i]),
            .casc_i (casc_q[i]),
            .d_i    (d),
            .q_i    (q),
            .cin_i  (c_in),
            .cas_i  (cas_in),
            .f_o    (f),
            .cout_o (c_out)
        );

        lcell_reg u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .aclr_i  (aclr_i),
            .run_i   (run),
            .ena_i   (ena_i),
            .sclr_i  (sclr_i),
            .sload_i (sload_i),
            .fn_i    (f),
            .ld_i    (d[LUT_IN-1]),
            .pre_i   (pre_q[i]),
            .q_o     (q)
        );

        assign comb_o[i] = f;
        assign reg_o[i]  = q;
    end

    assign cout_o = g_cell[N-1].c_out;

endmodule

// File: tb/lcell_slice_bench.sv
module lcell_slice_bench;
    import lcell_pkg::*;

    localparam int N = 8;

    logic clk = 1'b0;
    always #4ns clk = ~clk;

    logic rst_n, aclr_i, ena_i, sclr_i, sload_i, cin_i;
    logic [N*4-1:0]  data_i;
    logic [N*2-1:0]  cfg_mode_i;
    logic [N*16-1:0] cfg_lut_i;
    logic [N-1:0]    cfg_csel_i, cfg_casc_i, cfg_pre_i;
    logic [N-1:0]    comb_o, reg_o;
    logic            cout_o;

    lcell_slice #(.N(N)) u_lcell_slice (
        .clk(clk), .rst_n(rst_n), .aclr_i(aclr_i), .ena_i(ena_i),
        .sclr_i(sclr_i), .sload_i(sload_i), .cin_i(cin_i), .data_i(data_i),
        .cfg_mode_i(cfg_mode_i), .cfg_lut_i(cfg_lut_i), .cfg_csel_i(cfg_csel_i),
        .cfg_casc_i(cfg_casc_i), .cfg_pre_i(cfg_pre_i),
        .comb_o(comb_o), .reg_o(reg_o), .cout_o(cout_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference
    int        m_mode [N];
    bit [15:0] m_lut  [N];
    bit        m_csel [N], m_casc [N], m_pre [N];
    bit        m_q [N], m_f [N], m_c [N];
    bit        m_run;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic m_capture();
        for (int i = 0; i < N; i++) begin
            m_mode[i] = int'(cfg_mode_i[2*i +: 2]);
            m_lut[i]  = cfg_lut_i[16*i +: 16];
            m_csel[i] = cfg_csel_i[i];
            m_casc[i] = cfg_casc_i[i];
            m_pre[i]  = cfg_pre_i[i];
        end
    endtask

    task automatic m_eval();
        if (!rst_n || aclr_i) for (int i = 0; i < N; i++) m_q[i] = m_pre[i];
        for (int i = 0; i < N; i++) begin
            bit c, cas, g;
            bit [3:0] d;
            int idx;
            c   = (i == 0) ? cin_i : m_c[i-1];
            cas = (i == 0) ? 1'b1 : m_f[i-1];
            d   = data_i[4*i +: 4];
            if (m_mode[i] == 2) begin
                m_f[i] = m_q[i] ^ (d[0] & c);
                m_c[i] = c & (d[1] ? m_q[i] : !m_q[i]);
            end else begin
                if (m_mode[i] == 1) begin
                    idx    = d[0] + 2 * d[1] + 4 * c;
                    g      = m_lut[i][idx];
                    m_c[i] = m_lut[i][idx + 8];
                end else begin
                    idx    = d[0] + 2 * d[1] + 4 * (m_csel[i] ? c : d[2]) + 8 * d[3];
                    g      = m_lut[i][idx];
                    m_c[i] = 1'b0;
                end
                m_f[i] = m_casc[i] ? (g & cas) : g;
            end
        end
    endtask

    task automatic m_tick();
        if (!rst_n) begin
            m_capture();
            m_run = 1'b0;
            for (int i = 0; i < N; i++) m_q[i] = m_pre[i];
        end else if (!m_run) begin
            m_capture();
            m_run = 1'b1;
            for (int i = 0; i < N; i++) m_q[i] = m_pre[i];
        end else if (aclr_i) begin
            for (int i = 0; i < N; i++) m_q[i] = m_pre[i];
        end else if (ena_i) begin
            for (int i = 0; i < N; i++)
                m_q[i] = sclr_i ? 1'b0 : (sload_i ? data_i[4*i+3] : m_f[i]);
        end
    endtask

    function automatic logic [N-1:0] pack(bit v [N]);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = v[i];
        return r;
    endfunction

    function automatic logic [N-1:0] d3_vec();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = data_i[4*i+3];
        return r;
    endfunction

    // inputs are moved 1 ns after a rising edge; compare 1 ns later
    task automatic step(string req);
        #1ns;
        m_eval();
        chk(req, 32'(comb_o), 32'(pack(m_f)));
        chk(req, 32'(reg_o),  32'(pack(m_q)));
        chk(req, 32'(cout_o), 32'(m_c[N-1]));
        @(posedge clk);
        m_tick();
        #1ns;
    endtask

    task automatic set_cfg(logic [1:0] md, logic [15:0] lut, logic [N-1:0] csel,
                           logic [N-1:0] casc, logic [N-1:0] pre);
        for (int i = 0; i < N; i++) begin
            cfg_mode_i[2*i +: 2]  = md;
            cfg_lut_i[16*i +: 16] = lut;
        end
        cfg_csel_i = csel;
        cfg_casc_i = casc;
        cfg_pre_i  = pre;
    endtask

    task automatic do_reset();
        ena_i = 1'b0; sclr_i = 1'b0; sload_i = 1'b0; aclr_i = 1'b0;
        rst_n = 1'b0;
        step("R1");
        step("R1");
        #1ns;
        chk("R1", 32'(reg_o), 32'(cfg_pre_i));
        rst_n = 1'b1;
        ena_i = 1'b1; sload_i = 1'b1; data_i = '1;
        step("R2");
        chk("R2", 32'(reg_o), 32'(cfg_pre_i));   // config edge: no load
        ena_i = 1'b0; sload_i = 1'b0;
    endtask

    initial begin
        logic [N-1:0] prev;
        int cnt;
        rst_n = 1'b0; aclr_i = 1'b0; ena_i = 1'b0; sclr_i = 1'b0; sload_i = 1'b0;
        cin_i = 1'b0; data_i = '0;
        // AND-cascade of all 4*N inputs, power-up pattern A5
        set_cfg(2'b00, 16'h8000, '0, {{(N-1){1'b1}}, 1'b0}, 8'hA5);
        repeat (2) @(posedge clk);
        m_capture();
        for (int i = 0; i < N; i++) m_q[i] = m_pre[i];
        m_run = 1'b0;
        #1ns;
        do_reset();
        chk("R1", 32'(reg_o), 32'h0A5);
        ena_i = 1'b1;
        for (int k = 0; k < 30; k++) begin
            data_i = (k % 5 == 0) ? ~(32'h1 << k) : $urandom;
            step("R3");
        end
        data_i = '1;
        step("R6");
        chk("R6", 32'(comb_o[N-1]), 32'(1));
        chk("R7", 32'(reg_o), 32'hFF);
        // configuration changes in run state are ignored
        set_cfg(2'b01, 16'h0000, '1, '0, '0);
        for (int k = 0; k < 5; k++) step("R1");
        chk("R1", 32'(comb_o[N-1]), 32'(1));
        // enable low holds against clear and load
        data_i = $urandom;
        prev = reg_o;
        ena_i = 1'b0; sclr_i = 1'b1; sload_i = 1'b1;
        step("R8");
        chk("R8", 32'(reg_o), 32'(prev));
        ena_i = 1'b1;
        step("R9");
        chk("R9", 32'(reg_o), 32'h0);
        sclr_i = 1'b0;
        data_i = 32'h8808_0880;
        step("R10");
        chk("R10", 32'(reg_o), 32'(d3_vec()));
        sload_i = 1'b0;
        data_i = '1;
        step("R7");
        aclr_i = 1'b1;
        #1ns;
        chk("R11", 32'(reg_o), 32'h0A5);
        step("R11");
        step("R11");
        chk("R11", 32'(reg_o), 32'h0A5);
        aclr_i = 1'b0;
        step("R11");

        // NOR cascade by De Morgan: per-cell NOR joined with AND
        set_cfg(2'b00, 16'h0001, '0, {{(N-1){1'b1}}, 1'b0}, '0);
        do_reset();
        ena_i = 1'b1;
        for (int k = 0; k < 12; k++) begin
            data_i = (k < 4) ? '0 : (32'h1 << (k * 3));
            step("R6");
            chk("R6", 32'(comb_o[N-1]), 32'(~|data_i));
        end

        // adder: seven arithmetic cells plus a carry pick-off cell
        set_cfg(2'b01, 16'hE896, {1'b1, {(N-1){1'b0}}}, '0, '0);
        cfg_mode_i[2*(N-1) +: 2]  = 2'b00;
        cfg_lut_i[16*(N-1) +: 16] = 16'hF0F0;
        do_reset();
        for (int k = 0; k < 25; k++) begin
            int a, b;
            data_i = $urandom;
            if (k == 0) data_i = 32'h0333_3333;
            cin_i = (k % 3 == 0);
            a = 0; b = 0;
            for (int i = 0; i < N-1; i++) begin
                a += int'(data_i[4*i]) << i;
                b += int'(data_i[4*i+1]) << i;
            end
            step("R4");
            chk("R4", 32'(comb_o), 32'((a + b + int'(cin_i)) & 8'hFF));
            chk("R4", 32'(cout_o), 32'(0));
        end

        // counter
        set_cfg(2'b10, 16'h0000, '0, '0, '0);
        cin_i = 1'b1;
        do_reset();
        ena_i = 1'b1;
        data_i = 32'h3333_3333;
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            step("R5");
            cnt = (cnt + 1) & 8'hFF;
            chk("R5", 32'(reg_o), 32'(cnt));
        end
        data_i = 32'h1111_1111;
        for (int k = 0; k < 5; k++) begin
            step("R5");
            cnt = (cnt - 1) & 8'hFF;
            chk("R5", 32'(reg_o), 32'(cnt));
        end
        data_i = 32'h2222_2222;
        for (int k = 0; k < 3; k++) begin
            step("R5");
            chk("R5", 32'(reg_o), 32'(cnt));
        end
        data_i = 32'hBBBB_BBB3;
        sload_i = 1'b1;
        step("R10");
        chk("R10", 32'(reg_o), 32'hFE);
        sload_i = 1'b0;
        data_i = 32'h3333_3333;
        step("R5");
        chk("R5", 32'(reg_o), 32'hFF);
        #1ns;
        chk("R5", 32'(cout_o), 32'(1));
        step("R5");
        chk("R5", 32'(reg_o), 32'h00);

        // random configurations, all four style codes
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < N; i++) begin
                cfg_mode_i[2*i +: 2]  = (r == 0) ? 2'b11 : 2'($urandom);
                cfg_lut_i[16*i +: 16] = 16'($urandom);
            end
            cfg_csel_i = 8'($urandom);
            cfg_casc_i = 8'($urandom);
            cfg_pre_i  = 8'($urandom);
            do_reset();
            for (int k = 0; k < 150; k++) begin
                data_i  = $urandom;
                cin_i   = 1'($urandom);
                ena_i   = ($urandom % 8) != 0;
                sclr_i  = ($urandom % 16) == 0;
                sload_i = ($urandom % 10) == 0;
                aclr_i  = ($urandom % 25) == 0;
                step("R12");
            end
            aclr_i = 1'b0;
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        finished = 1;
        $finish;
    end

    initial begin
        #1ms;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule